// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave (x16)

This block models the slave side of a three-wire serial EEPROM organised as 16-bit words. A host selects it with a chip-select pin, supplies a serial clock, and shifts commands and data in on a serial input. Replies and status leave on a serial output with its own output-enable, so a tri-state pad can sit outside the block. The storage is a register array inside the block. It resets to all zeros.

Every pin is sampled by a fast system clock, and rising serial-clock edges are found inside the block. A command is a start bit, a two-bit opcode and a six-bit address. A READ returns one dummy zero and then words, one after another, with an address that counts up on its own. A WRITE stores one to eight words of a page. The words are held in a page buffer and written to the array in one self-timed cycle that starts when chip-select drops. While that cycle runs, the host can raise chip-select and poll the serial output for busy or ready. The host sets the pace through the serial clock, so there is no stream handshake and no back-pressure. All pins are plain control and data wires.

Top module: `serial_eeprom_x16`

## Requirements
- R1: A command starts with the first 1 sampled on a rising serial-clock edge while chip-select is high; zeros before it are ignored. Next come a 2-bit opcode (10 = READ, 01 = WRITE) and a 6-bit address, most significant bit first.
- R2: After the last address bit of a READ, ser_out_en goes high and ser_out gives one dummy 0. The addressed word then follows MSB first, one bit per rising serial-clock edge.
- R3: While chip-select stays high during a READ, each further 16 rising edges return the next word, with no dummy bit between words.
- R4: A sequential READ moves from address 63 to address 0.
- R5: After a WRITE, dropping chip-select commits the received word with no further serial-clock edges. The new value replaces the old one in full, with no erase command.
- R6: A WRITE may carry more words. The low 3 address bits count up and wrap within the 8-word page. A ninth or later word overwrites the buffer slot it lands on, and all slots that were received are committed in one cycle.
- R7: From commit until WRITE_CYCLES system clocks have passed, ser_out is driven 0 (busy) whenever chip-select is high. After that it is driven 1 (ready), until the next accepted start bit.
- R8: While the store cycle runs, start bits are not accepted, so a command sent during busy has no effect.
- R9: After reset ser_out_en is 0 and every word reads as 0. ser_out_en is 0 whenever chip-select is low.
- R10: A WRITE that ends before a full 16-bit word has been received starts no store cycle, leaves the memory unchanged, and shows no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample every pin |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel | input | 1 | Chip select, active high |
| ser_clk | input | 1 | Serial clock from the host |
| ser_in | input | 1 | Serial command and data input |
| ser_out | output | 1 | Serial data or ready/busy output |
| ser_out_en | output | 1 | Output enable for ser_out |

## Verification
The bench keeps the default 6-bit address, 16-bit word and 8-word page. This lets it reach the 63-to-0 wrap, page-slot wrap and overflow past eight words in short runs. It shortens WRITE_CYCLES to 300 system clocks. The busy window then fits in a few hundred clocks, yet still outlasts a full nine-bit command, so a command rejected during busy can be observed.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_READ,
    ST_WRITE,
    ST_SKIP
  } ctl_state_t;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_pin,
  input  logic sk_pin,
  input  logic di_pin,
  output logic cs_s,
  output logic di_s,
  output logic sk_rise
);
  localparam int NPINS = 3;

  logic [NPINS-1:0] pins_in;
  logic [NPINS-1:0] pins_s;
  logic             sk_prev;

  assign pins_in = {di_pin, sk_pin, cs_pin};

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pins_in[p]};
      end
      assign pins_s[p] = chain_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_prev <= 1'b0;
    else        sk_prev <= pins_s[1];
  end

  assign cs_s    = pins_s[0];
  assign di_s    = pins_s[2];
  assign sk_rise = pins_s[1] & ~sk_prev;
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              di_s,
  input  logic              sk_rise,
  input  logic              busy,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] rd_addr_nxt,
  output logic              wr_start,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              word_valid,
  output logic [DATA_W-1:0] word,
  output logic              commit_req,
  output logic              ser_out,
  output logic              ser_out_en
);
  localparam int IW      = $clog2(DATA_W);
  localparam int CNT_MAX = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CW      = $clog2(CNT_MAX);

  ctl_state_t        state;
  logic [CW-1:0]     cnt;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] addr_sr;
  logic [DATA_W-1:0] data_sr;
  logic [ADDR_W-1:0] rd_addr;
  logic [IW-1:0]     rd_idx;
  logic [IW-1:0]     nxt_idx;
  logic              dummy;
  logic              do_bit;
  logic              have_word;
  logic              poll_en;
  logic [ADDR_W-1:0] a_nxt;
  logic [DATA_W-1:0] d_nxt;

  assign a_nxt = {addr_sr[ADDR_W-2:0], di_s};
  assign d_nxt = {data_sr[DATA_W-2:0], di_s};

  // next read position: the dummy bit leads into the MSB of the same word,
  // the LSB leads into the MSB of the following address
  always_comb begin
    rd_addr_nxt = rd_addr;
    nxt_idx     = rd_idx;
    if (dummy) begin
      nxt_idx = IW'(DATA_W-1);
    end else if (rd_idx == '0) begin
      rd_addr_nxt = rd_addr + 1'b1;
      nxt_idx     = IW'(DATA_W-1);
    end else begin
      nxt_idx = rd_idx - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      opc        <= '0;
      addr_sr    <= '0;
      data_sr    <= '0;
      rd_addr    <= '0;
      rd_idx     <= '0;
      dummy      <= 1'b0;
      do_bit     <= 1'b0;
      have_word  <= 1'b0;
      poll_en    <= 1'b0;
      wr_start   <= 1'b0;
      wr_addr    <= '0;
      word_valid <= 1'b0;
      word       <= '0;
      commit_req <= 1'b0;
    end else begin
      wr_start   <= 1'b0;
      word_valid <= 1'b0;
      commit_req <= 1'b0;
      if (!cs_s) begin
        if (state == ST_WRITE && have_word) begin
          commit_req <= 1'b1;
          poll_en    <= 1'b1;
        end
        state <= ST_IDLE;
      end else if (sk_rise) begin
        unique case (state)
          ST_IDLE: begin
            if (di_s && !busy) begin
              state   <= ST_OPC;
              cnt     <= '0;
              poll_en <= 1'b0;
            end
          end
          ST_OPC: begin
            opc <= {opc[0], di_s};
            if (cnt == CW'(1)) begin
              state <= ST_ADDR;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ADDR: begin
            addr_sr <= a_nxt;
            if (cnt == CW'(ADDR_W-1)) begin
              cnt <= '0;
              if (opc == OP_READ) begin
                state   <= ST_READ;
                rd_addr <= a_nxt;
                dummy   <= 1'b1;
                do_bit  <= 1'b0;
              end else if (opc == OP_WRITE) begin
                state     <= ST_WRITE;
                wr_start  <= 1'b1;
                wr_addr   <= a_nxt;
                have_word <= 1'b0;
              end else begin
                state <= ST_SKIP;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_READ: begin
            do_bit  <= rdata[nxt_idx];
            rd_addr <= rd_addr_nxt;
            rd_idx  <= nxt_idx;
            dummy   <= 1'b0;
          end
          ST_WRITE: begin
            data_sr <= d_nxt;
            if (cnt == CW'(DATA_W-1)) begin
              cnt        <= '0;
              word_valid <= 1'b1;
              word       <= d_nxt;
              have_word  <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ser_out_en = cs_s && ((state == ST_READ) || (state == ST_IDLE && poll_en));
  assign ser_out    = (state == ST_READ) ? do_bit : ~busy;

  // R2
  // the first bit after entering a read is the dummy zero
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) != ST_READ && state == ST_READ) |-> (do_bit == 1'b0 && dummy));

  // R3
  // after the LSB of a word the read address advances by one
  seq_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && cs_s && sk_rise && !dummy && rd_idx == '0)
      |=> (rd_addr == $past(rd_addr) + 1'b1));

  // R8
  // no command is started while the store cycle runs
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state == ST_IDLE) |=> (state == ST_IDLE));

  // R9
  // the output is never enabled once chip-select is low
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |-> !ser_out_en);
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_start,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic                     word_valid,
  input  logic [DATA_W-1:0]        word,
  output logic [ADDR_W-PAGE_W-1:0] page_base,
  output logic [(1<<PAGE_W)-1:0]   slot_valid,
  output logic [DATA_W-1:0]        slot_q [1<<PAGE_W]
);
  localparam int PAGES = 1 << PAGE_W;

  logic [PAGE_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_base  <= '0;
      ptr        <= '0;
      slot_valid <= '0;
      for (int i = 0; i < PAGES; i++) slot_q[i] <= '0;
    end else if (wr_start) begin
      page_base  <= wr_addr[ADDR_W-1:PAGE_W];
      ptr        <= wr_addr[PAGE_W-1:0];
      slot_valid <= '0;
    end else if (word_valid) begin
      slot_q[ptr]     <= word;
      slot_valid[ptr] <= 1'b1;
      ptr             <= ptr + 1'b1;
    end
  end

  // R6
  // each received word moves the slot pointer on, wrapping inside the page
  page_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !wr_start) |=> (ptr == $past(ptr) + 1'b1));

  // R6
  // the slot just written is marked for commit
  slot_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !wr_start) |=> slot_valid[$past(ptr)]);
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 16,
  parameter int PAGE_W       = 3,
  parameter int WRITE_CYCLES = 2500
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit_req,
  input  logic [ADDR_W-PAGE_W-1:0] page_base,
  input  logic [(1<<PAGE_W)-1:0]   slot_valid,
  input  logic [DATA_W-1:0]        slot_q [1<<PAGE_W],
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rdata,
  output logic                     busy
);
  localparam int PAGES = 1 << PAGE_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW    = $clog2(WRITE_CYCLES + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [TW-1:0]     timer;
  logic              finish;

  assign finish = busy && (timer == '0);
  assign rdata  = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      timer <= '0;
    end else if (commit_req && !busy) begin
      busy  <= 1'b1;
      timer <= TW'(WRITE_CYCLES - 1);
    end else if (busy) begin
      if (timer == '0) busy <= 1'b0;
      else             timer <= timer - 1'b1;
    end
  end

  // a whole-word store replaces every bit, which covers the clear phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (finish) begin
      for (int i = 0; i < PAGES; i++) begin
        if (slot_valid[i]) mem[{page_base, PAGE_W'(i)}] <= slot_q[i];
      end
    end
  end

  // R7
  // busy holds while the cycle counter has not run out
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && timer != '0) |=> (busy && timer == $past(timer) - 1'b1));

  // R5
  // a commit request starts the self-timed cycle
  commit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_req && !busy) |=> busy);

  // R7
  // the cycle ends right after the final count
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy);
endmodule

// File: rtl/serial_eeprom_x16.sv
module serial_eeprom_x16 #(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 16,
  parameter int PAGE_W       = 3,
  parameter int WRITE_CYCLES = 2500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_sel,
  input  logic ser_clk,
  input  logic ser_in,
  output logic ser_out,
  output logic ser_out_en
);
  localparam int PAGES = 1 << PAGE_W;
  localparam int PB_W  = ADDR_W - PAGE_W;

  logic              cs_s;
  logic              di_s;
  logic              sk_rise;
  logic              busy;
  logic [DATA_W-1:0] rdata;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_start;
  logic [ADDR_W-1:0] wr_addr;
  logic              word_valid;
  logic [DATA_W-1:0] word;
  logic              commit_req;
  logic [PB_W-1:0]   page_base;
  logic [PAGES-1:0]  slot_valid;
  logic [DATA_W-1:0] slot_q [PAGES];

  eep_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_pin  (chip_sel),
    .sk_pin  (ser_clk),
    .di_pin  (ser_in),
    .cs_s    (cs_s),
    .di_s    (di_s),
    .sk_rise (sk_rise)
  );

  eep_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_s        (cs_s),
    .di_s        (di_s),
    .sk_rise     (sk_rise),
    .busy        (busy),
    .rdata       (rdata),
    .rd_addr_nxt (rd_addr),
    .wr_start    (wr_start),
    .wr_addr     (wr_addr),
    .word_valid  (word_valid),
    .word        (word),
    .commit_req  (commit_req),
    .ser_out     (ser_out),
    .ser_out_en  (ser_out_en)
  );

  eep_page_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_page (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_start   (wr_start),
    .wr_addr    (wr_addr),
    .word_valid (word_valid),
    .word       (word),
    .page_base  (page_base),
    .slot_valid (slot_valid),
    .slot_q     (slot_q)
  );

  eep_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_req (commit_req),
    .page_base  (page_base),
    .slot_valid (slot_valid),
    .slot_q     (slot_q),
    .rd_addr    (rd_addr),
    .rdata      (rdata),
    .busy       (busy)
  );
endmodule

// File: tb/serial_eeprom_x16_bench.sv
`timescale 1ns/1ps
module serial_eeprom_x16_bench;
  localparam int WRC  = 300;
  localparam int HALF = 6;
  localparam int WD   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_sel = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_in = 1'b0;
  logic ser_out;
  logic ser_out_en;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [64];
  logic [15:0] wbuf  [16];

  always #10 clk = ~clk;

  serial_eeprom_x16 #(.WRITE_CYCLES(WRC)) u_serial_eeprom_x16 (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .ser_clk(ser_clk),
    .ser_in(ser_in), .ser_out(ser_out), .ser_out_en(ser_out_en)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic o, output logic e);
    ser_in  = b;
    ser_clk = 1'b0;
    repeat (HALF) @(posedge clk);
    @(negedge clk);
    o = ser_out;
    e = ser_out_en;
    ser_clk = 1'b1;
    repeat (HALF) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] op, input int a);
    logic o, e;
    logic [5:0] ab;
    ab = a[5:0];
    send_bit(1'b1, o, e);
    send_bit(op[1], o, e);
    send_bit(op[0], o, e);
    for (int i = 5; i >= 0; i--) send_bit(ab[i], o, e);
  endtask

  function automatic int slot_addr(input int a, input int k);
    return (a & 56) | ((a + k) & 7);
  endfunction

  task automatic write_words(input int a, input int n);
    logic o, e;
    chip_sel = 1'b1;
    idle(3);
    send_cmd(2'b01, a);
    for (int k = 0; k < n; k++)
      for (int b = 15; b >= 0; b--) send_bit(wbuf[k][b], o, e);
    ser_clk  = 1'b0;
    idle(2);
    chip_sel = 1'b0;
    for (int k = 0; k < n; k++) model[slot_addr(a, k)] = wbuf[k];
    idle(4);
  endtask

  task automatic wait_ready();
    chip_sel = 1'b1;
    idle(6);
    chk(ser_out_en == 1'b1 && ser_out == 1'b0, "R7 busy status", {ser_out_en, ser_out}, 2'b10);
    idle(WRC + 20);
    chk(ser_out_en == 1'b1 && ser_out == 1'b1, "R7 ready status", {ser_out_en, ser_out}, 2'b11);
    chip_sel = 1'b0;
    idle(4);
  endtask

  task automatic read_check(input int a, input int n, input int lead, input string req);
    logic o, e;
    logic [15:0] w;
    chip_sel = 1'b1;
    idle(3);
    for (int z = 0; z < lead; z++) send_bit(1'b0, o, e);
    send_cmd(2'b10, a);
    send_bit(1'b0, o, e);
    chk(o == 1'b0 && e == 1'b1, "R2 dummy zero", {e, o}, 2'b10);
    for (int k = 0; k < n; k++) begin
      w = '0;
      for (int b = 0; b < 16; b++) begin
        send_bit(1'b0, o, e);
        w = {w[14:0], o};
      end
      chk(w == model[(a + k) % 64], req, w, model[(a + k) % 64]);
    end
    ser_clk  = 1'b0;
    idle(2);
    chip_sel = 1'b0;
    idle(4);
    chk(ser_out_en == 1'b0, "R9 oe low after deselect", ser_out_en, 1'b0);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic o, e;
    int seed_v;
    seed_v = $urandom(32'h5EED_0042);
    for (int i = 0; i < 64; i++) model[i] = '0;
    idle(5);
    chk(ser_out_en == 1'b0, "R9 reset oe", ser_out_en, 1'b0);
    rst_n = 1'b1;
    idle(5);
    chk(ser_out_en == 1'b0, "R9 idle oe", ser_out_en, 1'b0);
    read_check(10, 2, 0, "R9 reset contents zero");

    // R5 single write, then overwrite with no erase
    wbuf[0] = 16'hA5C3;
    write_words(5, 1);
    wait_ready();
    read_check(5, 1, 0, "R5 single word");
    wbuf[0] = 16'h5A3C;
    write_words(5, 1);
    wait_ready();
    read_check(5, 1, 0, "R5 overwrite replaces old value");

    // R6 page write of 10 words from offset 5 of page 3
    for (int k = 0; k < 10; k++) wbuf[k] = 16'h1000 + 16'(k * 16'h0111);
    write_words(29, 10);
    wait_ready();
    read_check(24, 8, 0, "R6 page wrap and overflow");

    // R4 wrap across the top of memory, R3 sequential words
    wbuf[0] = 16'hFEED;
    wbuf[1] = 16'h8001;
    write_words(62, 2);
    wait_ready();
    wbuf[0] = 16'h0F0F;
    wbuf[1] = 16'hF0F0;
    write_words(0, 2);
    wait_ready();
    read_check(62, 4, 0, "R4 wrap 63 to 0 and R3 sequential");

    // R1 leading zeros before the start bit
    read_check(62, 1, 3, "R1 leading zeros ignored");

    // R10 partial word discarded
    chip_sel = 1'b1;
    idle(3);
    send_cmd(2'b01, 5);
    for (int b = 0; b < 7; b++) send_bit(1'b1, o, e);
    ser_clk = 1'b0;
    idle(2);
    chip_sel = 1'b0;
    idle(4);
    chip_sel = 1'b1;
    idle(8);
    chk(ser_out_en == 1'b0, "R10 no status after partial", ser_out_en, 1'b0);
    chip_sel = 1'b0;
    idle(4);
    read_check(5, 1, 0, "R10 memory unchanged");

    // R8 command during busy is ignored
    wbuf[0] = 16'h3C3C;
    write_words(40, 1);
    chip_sel = 1'b1;
    idle(6);
    send_bit(1'b1, o, e);
    chk(o == 1'b0 && e == 1'b1, "R8 busy before command", {e, o}, 2'b10);
    send_bit(1'b1, o, e);
    send_bit(1'b0, o, e);
    for (int i = 0; i < 6; i++) begin
      send_bit(1'b0, o, e);
      chk(o == 1'b0 && e == 1'b1, "R8 status kept during busy", {e, o}, 2'b10);
    end
    ser_clk = 1'b0;
    idle(WRC);
    chk(ser_out_en == 1'b1 && ser_out == 1'b1, "R8 no read started", {ser_out_en, ser_out}, 2'b11);
    chip_sel = 1'b0;
    idle(4);
    read_check(40, 1, 0, "R8 stored word intact");

    // random page writes and sequential reads
    for (int it = 0; it < 6; it++) begin
      int a, n, ra;
      a  = int'($urandom % 64);
      n  = 1 + int'($urandom % 10);
      for (int k = 0; k < n; k++) wbuf[k] = 16'($urandom);
      write_words(a, n);
      wait_ready();
      ra = (a & 56) + int'($urandom % 8);
      read_check(ra, 3, 0, "R6 random page write");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule